// File: doc/BRIEF.md
# Four-Phase Byte ALU Executor

This block runs single-word 8-bit accumulator instructions on a small banked register-file datapath. An instruction word is accepted while the block sits in its decode phase. Each instruction then takes exactly four clock cycles: decode, operand fetch, compute, and write-back. Two opcodes do real work. Add-with-carry adds the working register W, a data-memory byte and the carry flag. AND-literal masks W with an 8-bit constant. Every other opcode runs through the same four phases as a no-operation.

The block keeps W, a bank select register, a five-bit status word and a banked byte memory. Add-with-carry picks its memory operand in one of two ways: from the bank named by the bank select register, or from a fixed split "access" window (low offsets in bank 0, high offsets in the last bank). A destination bit sends the sum either to W or back to memory. When the extended-instruction option is on, an access-window add with a low offset would need indexed addressing, which this block does not provide. It raises an unsupported flag for that instruction and leaves all state unchanged.

Fetch, the program counter and the other opcodes are outside this block. A load port lets the surrounding logic seed W, the bank select register, the status word or a memory byte while no instruction is in flight. A combinational peek port reads any memory byte.

Top module: `qphase_alu`

## Requirements
- R1: `phase_out` reads 0 (decode) while idle. An instruction is accepted on a clock edge where `phase_out`=0 and `insn_valid`=1. `phase_out` then steps 1, 2, 3 and back to 0, one step per clock, whatever `insn_valid` does meanwhile. `insn_ready` is high only while `phase_out`=0.
- R2: A clock edge with `rst_n` low sets W, the bank select register and the status word to 0, `phase_out` to 0 and `unsupp_mode` low, even in the middle of an instruction. Memory contents are not reset.
- R3: Add-with-carry is encoded with word bits [15:10]=001000, bit 9 as destination d, bit 8 as bank mode a, and bits [7:0] as offset f. It computes (W + M + C) mod 256. With d=0 the result goes to W and memory is unchanged. With d=1 the result goes to the operand's memory byte and W is unchanged. The new W, status and memory byte are visible after the fourth edge, counting the accepting edge.
- R4: The memory address is {bank, f}. With a=1 the bank is the bank select register, which keeps only log2(BANKS) bits of the loaded value. With a=0 the bank is 0 for f<=5Fh and BANKS-1 for f>=60h.
- R5: Status bits are C=bit 0, DC=bit 1, Z=bit 2, OV=bit 3, N=bit 4. Add-with-carry sets C to the carry out of bit 7 and DC to the carry out of bit 3, both counting the carry-in. OV is set on signed overflow, N equals result bit 7, and Z is set when the result byte is zero.
- R6: AND-literal is encoded with word bits [15:8]=0Bh and bits [7:0] as literal k. It writes W AND k to W, updates N and Z, and leaves C, DC and OV unchanged.
- R7: Any other word takes four phases and changes no W, status or memory.
- R8: The instruction is unsupported when it is an add-with-carry with a=0 and f<=5Fh and `ext_mode_en` is high at acceptance. For that instruction `unsupp_mode` is high in phases 1 to 3 and no W, status or memory change happens. In all other cases `unsupp_mode` is low.
- R9: A load happens only on an edge where `phase_out`=0, `insn_valid`=0 and `ld_en`=1. The target is chosen by `ld_sel`: 0=memory byte at `ld_addr`, 1=W, 2=bank select, 3=status (low 5 bits). At any other time the load port is ignored. `peek_data` always shows the memory byte at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 16 | Instruction word |
| ext_mode_en | input | 1 | Extended-instruction option enabled |
| insn_ready | output | 1 | High in decode phase |
| ld_en | input | 1 | Load request |
| ld_sel | input | 2 | Load target select |
| ld_addr | input | BANK_W+8 | Memory address for load |
| ld_data | input | 8 | Load value |
| peek_addr | input | BANK_W+8 | Memory read address |
| peek_data | output | 8 | Memory byte at peek_addr |
| w_out | output | 8 | Working register W |
| flags_out | output | 5 | Status word |
| phase_out | output | 2 | Current phase 0..3 |
| unsupp_mode | output | 1 | Indexed-addressing case flagged |

## Verification
The bench goes after the carry-in path in both nibble and byte carries. A design that dropped the carry-in would return 4Fh instead of 50h and miss the 00h result with both C and Z set. It also targets the signed-overflow case, where a design using the unsigned carry for OV would report no overflow. On the addressing side, the 5Fh/60h boundary of the access window and a bank select value wider than the implemented banks are hit, so a wrong split would corrupt a byte in the wrong bank. The last group covers the flagged indexed case, AND-literal preserving C/DC/OV, loads offered mid-instruction, and reset inside an instruction. A design that wrote state anyway, cleared the untouched flags or honoured a late load shows up on W, the flags or the peek port.

// File: rtl/qphase_alu_pkg.sv
// Shared types and constants for the four-phase byte ALU executor.
// Assumes 16-bit instruction words and 8-bit data.
package qphase_alu_pkg;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_PROC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADDC = 2'd1,
        OP_ANDK = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        LD_MEM    = 2'd0,
        LD_W      = 2'd1,
        LD_BANK   = 2'd2,
        LD_STATUS = 2'd3
    } ld_e;

    localparam int STATUS_W = 5;
    localparam int SF_C     = 0;
    localparam int SF_DC    = 1;
    localparam int SF_Z     = 2;
    localparam int SF_OV    = 3;
    localparam int SF_N     = 4;

    localparam logic [5:0] ADDC_PREFIX = 6'b001000;
    localparam logic [7:0] ANDK_PREFIX = 8'h0B;
    localparam logic [7:0] ACCESS_SPLIT = 8'h5F;

    typedef struct packed {
        op_e        op;
        logic       to_file;
        logic       unsupp;
        logic [7:0] lowbyte;
    } dec_t;

endpackage

// File: rtl/qpa_phase_seq.sv
// Phase sequencer: idles in decode, then walks read, process, write
// and returns to decode. Assumes start is only meaningful in decode.
module qpa_phase_seq
    import qphase_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase
);

    // Advance one phase per clock once an instruction has started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DECODE;
        end else if (phase == PH_DECODE) begin
            if (start) begin
                phase <= PH_READ;
            end
        end else begin
            phase <= phase_e'(phase + 2'd1);
        end
    end

endmodule

// File: rtl/qpa_decode.sv
// Instruction decoder: classifies the word, spots the unsupported
// indexed case and forms the banked memory address. Pure logic.
// Assumes BANKS is a power of two between 2 and 16.
module qpa_decode
    import qphase_alu_pkg::*;
#(
    parameter  int BANKS  = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = BANK_W + 8
) (
    input  logic [15:0]       insn,
    input  logic              ext_en,
    input  logic [BANK_W-1:0] bank_reg,
    output dec_t              dec,
    output logic [ADDR_W-1:0] addr
);

    logic              is_add;
    logic              is_and;
    logic              idx_case;
    logic [BANK_W-1:0] bank_sel;

    // Recognise the two working opcodes and the unsupported case.
    always_comb begin
        is_add   = (insn[15:10] == ADDC_PREFIX);
        is_and   = (insn[15:8] == ANDK_PREFIX);
        idx_case = is_add && !insn[8] && ext_en && (insn[7:0] <= ACCESS_SPLIT);
    end

    // Build the decoded record; the unsupported case becomes a no-op.
    always_comb begin
        dec.to_file = insn[9];
        dec.unsupp  = idx_case;
        dec.lowbyte = insn[7:0];
        if (idx_case) begin
            dec.op = OP_NONE;
        end else if (is_add) begin
            dec.op = OP_ADDC;
        end else if (is_and) begin
            dec.op = OP_ANDK;
        end else begin
            dec.op = OP_NONE;
        end
    end

    // Pick the bank: register-selected or the split access window.
    always_comb begin
        if (insn[8]) begin
            bank_sel = bank_reg;
        end else if (insn[7:0] <= ACCESS_SPLIT) begin
            bank_sel = '0;
        end else begin
            bank_sel = '1;
        end
        addr = {bank_sel, insn[7:0]};
    end

endmodule

// File: rtl/qpa_alu.sv
// Byte arithmetic unit: add with carry and AND, with status update.
// Pure logic; for OP_NONE it passes W and the status through unchanged.
module qpa_alu
    import qphase_alu_pkg::*;
(
    input  op_e                 op,
    input  logic [7:0]          w_in,
    input  logic [7:0]          opnd,
    input  logic [STATUS_W-1:0] status_in,
    output logic [7:0]          res,
    output logic [STATUS_W-1:0] status_out
);

    logic [8:0] sum9;
    logic [4:0] nib5;

    // Full and low-nibble sums, both including the carry-in.
    always_comb begin
        sum9 = {1'b0, w_in} + {1'b0, opnd} + {8'b0, status_in[SF_C]};
        nib5 = {1'b0, w_in[3:0]} + {1'b0, opnd[3:0]} + {4'b0, status_in[SF_C]};
    end

    // Select result and per-opcode flag updates.
    always_comb begin
        res        = w_in;
        status_out = status_in;
        case (op)
            OP_ADDC: begin
                res               = sum9[7:0];
                status_out[SF_C]  = sum9[8];
                status_out[SF_DC] = nib5[4];
                status_out[SF_OV] = (w_in[7] == opnd[7]) && (sum9[7] != w_in[7]);
                status_out[SF_N]  = sum9[7];
                status_out[SF_Z]  = (sum9[7:0] == 8'h00);
            end
            OP_ANDK: begin
                res              = w_in & opnd;
                status_out[SF_N] = res[7];
                status_out[SF_Z] = (res == 8'h00);
            end
            default: begin
                res        = w_in;
                status_out = status_in;
            end
        endcase
    end

endmodule

// File: rtl/qpa_bank_mem.sv
// Banked byte memory: one write port, two asynchronous read ports.
// One 256-byte array per bank. Contents are not reset.
module qpa_bank_mem #(
    parameter  int BANKS  = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = BANK_W + 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);

    logic [7:0] bank_rd_a [BANKS];
    logic [7:0] bank_rd_b [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [7:0] cells [256];

        // Write the addressed byte when this bank is selected.
        always_ff @(posedge clk) begin
            if (we && (waddr[ADDR_W-1:8] == BANK_W'(b))) begin
                cells[waddr[7:0]] <= wdata;
            end
        end

        assign bank_rd_a[b] = cells[raddr_a[7:0]];
        assign bank_rd_b[b] = cells[raddr_b[7:0]];
    end

    assign rdata_a = bank_rd_a[raddr_a[ADDR_W-1:8]];
    assign rdata_b = bank_rd_b[raddr_b[ADDR_W-1:8]];

endmodule

// File: rtl/qphase_alu.sv
// Four-phase byte ALU executor top. Accepts a word in decode, reads the
// operand in phase 1, computes in phase 2 and commits in phase 3.
// Assumes the surrounding logic seeds state through the load port only
// between instructions.
module qphase_alu
    import qphase_alu_pkg::*;
#(
    parameter  int BANKS  = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = BANK_W + 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [15:0]         insn_word,
    input  logic                ext_mode_en,
    output logic                insn_ready,
    input  logic                ld_en,
    input  logic [1:0]          ld_sel,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [7:0]          ld_data,
    input  logic [ADDR_W-1:0]   peek_addr,
    output logic [7:0]          peek_data,
    output logic [7:0]          w_out,
    output logic [STATUS_W-1:0] flags_out,
    output logic [1:0]          phase_out,
    output logic                unsupp_mode
);

    phase_e              phase;
    dec_t                dec_c;
    dec_t                dec_q;
    logic [ADDR_W-1:0]   addr_c;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          w_q;
    logic [BANK_W-1:0]   bank_q;
    logic [STATUS_W-1:0] status_q;
    logic [7:0]          opnd_q;
    logic [7:0]          res_c;
    logic [7:0]          res_q;
    logic [STATUS_W-1:0] stat_c;
    logic [STATUS_W-1:0] stat_q;
    logic [7:0]          mem_rd;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_waddr;
    logic [7:0]          mem_wdata;
    logic                accept;
    logic                load_ok;
    logic                file_wr;
    ld_e                 ld_kind;

    assign accept  = (phase == PH_DECODE) && insn_valid;
    assign load_ok = (phase == PH_DECODE) && !insn_valid && ld_en;
    assign ld_kind = ld_e'(ld_sel);

    qpa_phase_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (insn_valid),
        .phase (phase)
    );

    qpa_decode #(.BANKS(BANKS)) u_dec (
        .insn     (insn_word),
        .ext_en   (ext_mode_en),
        .bank_reg (bank_q),
        .dec      (dec_c),
        .addr     (addr_c)
    );

    qpa_alu u_alu (
        .op         (dec_q.op),
        .w_in       (w_q),
        .opnd       (opnd_q),
        .status_in  (status_q),
        .res        (res_c),
        .status_out (stat_c)
    );

    qpa_bank_mem #(.BANKS(BANKS)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (addr_q),
        .rdata_a (mem_rd),
        .raddr_b (peek_addr),
        .rdata_b (peek_data)
    );

    // Decode phase: hold the decoded record and address for the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            dec_q  <= dec_c;
            addr_q <= addr_c;
        end
    end

    // Read phase: latch the memory byte or the literal as operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
        end else if (phase == PH_READ) begin
            opnd_q <= (dec_q.op == OP_ADDC) ? mem_rd : dec_q.lowbyte;
        end
    end

    // Process phase: latch the computed result and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            stat_q <= '0;
        end else if (phase == PH_PROC) begin
            res_q  <= res_c;
            stat_q <= stat_c;
        end
    end

    // Write phase commit, or a seed load while idle in decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q      <= '0;
            bank_q   <= '0;
            status_q <= '0;
        end else if (phase == PH_WRITE) begin
            if (dec_q.op != OP_NONE) begin
                status_q <= stat_q;
                if (!((dec_q.op == OP_ADDC) && dec_q.to_file)) begin
                    w_q <= res_q;
                end
            end
        end else if (load_ok) begin
            case (ld_kind)
                LD_W:      w_q      <= ld_data;
                LD_BANK:   bank_q   <= ld_data[BANK_W-1:0];
                LD_STATUS: status_q <= ld_data[STATUS_W-1:0];
                default:   w_q      <= w_q;
            endcase
        end
    end

    // Memory write source: add result to file, else a seed load.
    always_comb begin
        file_wr = (phase == PH_WRITE) && (dec_q.op == OP_ADDC) && dec_q.to_file;
        mem_we  = file_wr || (load_ok && (ld_kind == LD_MEM));
        if (file_wr) begin
            mem_waddr = addr_q;
            mem_wdata = res_q;
        end else begin
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end
    end

    assign insn_ready  = (phase == PH_DECODE);
    assign phase_out   = phase;
    assign w_out       = w_q;
    assign flags_out   = status_q;
    assign unsupp_mode = dec_q.unsupp && (phase != PH_DECODE);

endmodule

// File: rtl/qphase_alu_chk.sv
// Property checker for qphase_alu, bound to every instance. Watches the
// ports only and keeps its own copy of the accepted opcode byte.
module qphase_alu_chk
    import qphase_alu_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                insn_valid,
    input logic [7:0]          insn_hi,
    input logic [1:0]          phase,
    input logic [7:0]          w_val,
    input logic [STATUS_W-1:0] flags,
    input logic                unsupp
);

    logic [7:0] cap_hi;

    // Remember the opcode byte of the instruction in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hi <= 8'h00;
        end else if ((phase == 2'd0) && insn_valid) begin
            cap_hi <= insn_hi;
        end
    end

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && !insn_valid) |=> (phase == 2'd0));

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && insn_valid) |=> (phase == 2'd1));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd0) |=> (phase == $past(phase) + 2'd1));

    p_reset_state_r2: assert property (@(posedge clk)
        !rst_n |=> (w_val == 8'h00 && flags == '0 && phase == 2'd0 && !unsupp));

    p_no_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 || phase == 2'd2) |=> ($stable(w_val) && $stable(flags)));

    p_and_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && cap_hi == ANDK_PREFIX) |=>
        ($stable(flags[SF_C]) && $stable(flags[SF_DC]) && $stable(flags[SF_OV])));

    p_unsupp_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unsupp |-> (phase != 2'd0));

    p_unsupp_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && unsupp) |=> ($stable(w_val) && $stable(flags)));

endmodule

bind qphase_alu qphase_alu_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_hi    (insn_word[15:8]),
    .phase      (phase_out),
    .w_val      (w_out),
    .flags      (flags_out),
    .unsupp     (unsupp_mode)
);

// File: tb/qphase_alu_tb_top.sv
// Bench for qphase_alu: a behavioural reference model stepped on every
// rising edge and compared on every falling edge, plus directed checks.
module qphase_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BANKS      = 4;
    localparam int ADDR_W     = 10;
    localparam int MAX_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              insn_valid = 1'b0;
    logic [15:0]       insn_word = 16'h0000;
    logic              ext_mode_en = 1'b0;
    logic              ld_en = 1'b0;
    logic [1:0]        ld_sel = 2'd0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [7:0]        ld_data = 8'h00;
    logic [ADDR_W-1:0] peek_addr = '0;
    logic              insn_ready;
    logic [7:0]        peek_data;
    logic [7:0]        w_out;
    logic [4:0]        flags_out;
    logic [1:0]        phase_out;
    logic              unsupp_mode;

    int checks = 0;
    int fails  = 0;

    qphase_alu #(.BANKS(BANKS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_valid  (insn_valid),
        .insn_word   (insn_word),
        .ext_mode_en (ext_mode_en),
        .insn_ready  (insn_ready),
        .ld_en       (ld_en),
        .ld_sel      (ld_sel),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .peek_addr   (peek_addr),
        .peek_data   (peek_data),
        .w_out       (w_out),
        .flags_out   (flags_out),
        .phase_out   (phase_out),
        .unsupp_mode (unsupp_mode)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_phase = 0;
    int m_w = 0;
    int m_bank = 0;
    int m_st = 0;
    int m_pend = 0;
    int m_addr = 0;
    bit m_unsupp = 0;
    bit model_live = 0;
    int m_mem [int];

    function automatic int map_addr(int word, int bank);
        int f;
        f = word & 255;
        if (((word >> 8) & 1) == 1) return bank * 256 + f;
        if (f <= 'h5F) return f;
        return (BANKS - 1) * 256 + f;
    endfunction

    task automatic model_execute();
        int op;
        int c;
        int s;
        int r;
        int lo;
        int ws;
        int os;
        int ss;
        int nst;
        if (m_unsupp) return;
        if ((m_pend >> 10) == 8) begin
            op = m_mem.exists(m_addr) ? m_mem[m_addr] : 0;
            c  = m_st & 1;
            s  = m_w + op + c;
            r  = s & 255;
            lo = (m_w & 15) + (op & 15) + c;
            ws = (m_w > 127) ? m_w - 256 : m_w;
            os = (op > 127) ? op - 256 : op;
            ss = ws + os + c;
            nst = 0;
            if (s > 255) nst = nst | 1;
            if (lo > 15) nst = nst | 2;
            if (r == 0) nst = nst | 4;
            if (ss > 127 || ss < -128) nst = nst | 8;
            if (r > 127) nst = nst | 16;
            m_st = nst;
            if (((m_pend >> 9) & 1) == 1) m_mem[m_addr] = r;
            else m_w = r;
        end else if ((m_pend >> 8) == 'h0B) begin
            r = m_w & (m_pend & 255);
            m_st = (m_st & 11) | ((r == 0) ? 4 : 0) | ((r > 127) ? 16 : 0);
            m_w = r;
        end
    endtask

    // Step the model on each rising edge from the same input values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_w = 0; m_bank = 0; m_st = 0; m_unsupp = 0;
            model_live = 1;
        end else begin
            case (m_phase)
                0: begin
                    if (insn_valid) begin
                        m_pend   = int'(insn_word);
                        m_addr   = map_addr(m_pend, m_bank);
                        m_unsupp = ((m_pend >> 10) == 8) && (((m_pend >> 8) & 1) == 0)
                                   && ext_mode_en && ((m_pend & 255) <= 'h5F);
                        m_phase  = 1;
                    end else if (ld_en) begin
                        case (ld_sel)
                            2'd0: m_mem[int'(ld_addr)] = int'(ld_data);
                            2'd1: m_w = int'(ld_data);
                            2'd2: m_bank = int'(ld_data) % BANKS;
                            default: m_st = int'(ld_data) & 31;
                        endcase
                    end
                end
                3: begin
                    model_execute();
                    m_phase = 0;
                end
                default: m_phase = m_phase + 1;
            endcase
        end
    end

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (model_live && rst_n) begin
            chk("R1", "phase", 16'(phase_out), 16'(m_phase));
            chk("R1", "ready", 16'(insn_ready), 16'(m_phase == 0));
            chk("R3", "W", 16'(w_out), 16'(m_w));
            chk("R5", "status", 16'(flags_out), 16'(m_st));
            chk("R8", "unsupp", 16'(unsupp_mode), 16'(m_unsupp && (m_phase != 0)));
            if (m_mem.exists(int'(peek_addr)))
                chk("R4", "peek", 16'(peek_data), 16'(m_mem[int'(peek_addr)]));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_load(int sel, int addr, int data);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_addr = ADDR_W'(addr); ld_data = 8'(data);
        step();
        ld_en = 1'b0;
    endtask

    task automatic run_insn(logic [15:0] word, logic ext);
        insn_valid = 1'b1; insn_word = word; ext_mode_en = ext;
        step();
        insn_valid = 1'b0;
        repeat (3) step();
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) step();
        chk("R2", "reset W", 16'(w_out), 16'h00);
        chk("R2", "reset status", 16'(flags_out), 16'h00);
        chk("R2", "reset phase", 16'(phase_out), 16'h0);
        chk("R2", "reset unsupp", 16'(unsupp_mode), 16'h0);
        rst_n = 1'b1;
        step();

        // R3/R5: worked add example, bank 1 via bank select
        do_load(0, 'h102, 'h02);
        do_load(2, 0, 1);
        do_load(3, 0, 'h01);
        do_load(1, 0, 'h4D);
        peek_addr = ADDR_W'('h102);
        run_insn(16'h2102, 1'b0);
        chk("R3", "add to W", 16'(w_out), 16'h50);
        chk("R5", "add flags", 16'(flags_out), 16'h02);
        chk("R3", "file kept", 16'(peek_data), 16'h02);

        // R1/R7: phase walk with a non-opcode word
        insn_valid = 1'b1; insn_word = 16'h0C55;
        step();
        chk("R1", "phase 1", 16'(phase_out), 16'h1);
        insn_valid = 1'b0;
        step();
        chk("R1", "phase 2", 16'(phase_out), 16'h2);
        step();
        chk("R1", "phase 3", 16'(phase_out), 16'h3);
        step();
        chk("R1", "phase back", 16'(phase_out), 16'h0);
        chk("R7", "nop W", 16'(w_out), 16'h50);
        chk("R7", "nop status", 16'(flags_out), 16'h02);
        run_insn(16'h2402, 1'b0);
        chk("R7", "near-add nop W", 16'(w_out), 16'h50);

        // R6: AND literal
        do_load(1, 0, 'hA3);
        run_insn(16'h0B5F, 1'b0);
        chk("R6", "and W", 16'(w_out), 16'h03);
        chk("R6", "and status", 16'(flags_out), 16'h02);
        run_insn(16'h0B00, 1'b0);
        chk("R6", "and zero status", 16'(flags_out), 16'h06);
        do_load(1, 0, 'h80);
        run_insn(16'h0BF0, 1'b0);
        chk("R6", "and neg W", 16'(w_out), 16'h80);
        chk("R6", "and neg status", 16'(flags_out), 16'h12);

        // R4/R5: access window high half, overflow, result to file
        do_load(0, 'h370, 'h3F);
        do_load(0, 'h070, 'h55);
        do_load(1, 0, 'h40);
        do_load(3, 0, 'h01);
        peek_addr = ADDR_W'('h370);
        run_insn(16'h2270, 1'b1);
        chk("R3", "file dest W kept", 16'(w_out), 16'h40);
        chk("R5", "overflow status", 16'(flags_out), 16'h1A);
        chk("R4", "last bank written", 16'(peek_data), 16'h80);
        peek_addr = ADDR_W'('h070);
        step();
        chk("R4", "bank 0 untouched", 16'(peek_data), 16'h55);

        // R5: carry and zero together
        do_load(0, 'h010, 'h00);
        do_load(1, 0, 'hFF);
        do_load(3, 0, 'h01);
        run_insn(16'h2010, 1'b0);
        chk("R5", "wrap W", 16'(w_out), 16'h00);
        chk("R5", "wrap status", 16'(flags_out), 16'h07);

        // R4: bank select keeps only its low bits
        do_load(2, 0, 5);
        do_load(0, 'h1A0, 'h11);
        do_load(1, 0, 'h22);
        do_load(3, 0, 'h00);
        peek_addr = ADDR_W'('h1A0);
        run_insn(16'h23A0, 1'b0);
        chk("R4", "bank wrap file", 16'(peek_data), 16'h33);
        chk("R4", "bank wrap W", 16'(w_out), 16'h22);

        // R8: unsupported indexed case at the boundary offset
        do_load(1, 0, 'h10);
        do_load(3, 0, 'h01);
        do_load(0, 'h05F, 'h20);
        peek_addr = ADDR_W'('h05F);
        insn_valid = 1'b1; insn_word = 16'h225F; ext_mode_en = 1'b1;
        step();
        chk("R8", "flag phase 1", 16'(unsupp_mode), 16'h1);
        insn_valid = 1'b0;
        step();
        chk("R8", "flag phase 2", 16'(unsupp_mode), 16'h1);
        repeat (2) step();
        chk("R8", "flag cleared", 16'(unsupp_mode), 16'h0);
        chk("R8", "no W change", 16'(w_out), 16'h10);
        chk("R8", "no status change", 16'(flags_out), 16'h01);
        chk("R8", "no file change", 16'(peek_data), 16'h20);
        run_insn(16'h225F, 1'b0);
        chk("R8", "option off executes", 16'(peek_data), 16'h31);
        chk("R8", "option off status", 16'(flags_out), 16'h00);
        do_load(0, 'h360, 'h05);
        insn_valid = 1'b1; insn_word = 16'h2060; ext_mode_en = 1'b1;
        step();
        chk("R8", "60h supported", 16'(unsupp_mode), 16'h0);
        insn_valid = 1'b0;
        repeat (3) step();
        chk("R8", "60h result", 16'(w_out), 16'h15);
        ext_mode_en = 1'b0;

        // R9: loads offered mid-instruction or beside a valid word are ignored
        insn_valid = 1'b1; insn_word = 16'h0C00;
        step();
        insn_valid = 1'b0;
        ld_en = 1'b1; ld_sel = 2'd1; ld_data = 8'hEE;
        repeat (3) step();
        ld_en = 1'b0;
        chk("R9", "mid-insn load ignored", 16'(w_out), 16'h15);
        insn_valid = 1'b1; insn_word = 16'h0C00;
        ld_en = 1'b1; ld_sel = 2'd1; ld_data = 8'hEE;
        step();
        ld_en = 1'b0; insn_valid = 1'b0;
        repeat (3) step();
        chk("R9", "load beside insn ignored", 16'(w_out), 16'h15);
        do_load(1, 0, 'h5A);
        chk("R9", "idle load", 16'(w_out), 16'h5A);

        // R1: back-to-back instructions with valid held high
        insn_valid = 1'b1; insn_word = 16'h0B0F;
        repeat (4) step();
        insn_word = 16'h0B03;
        step();
        insn_valid = 1'b0;
        repeat (3) step();
        chk("R1", "back-to-back W", 16'(w_out), 16'h02);

        // R2: reset inside an instruction
        insn_valid = 1'b1; insn_word = 16'h0BFF;
        step();
        insn_valid = 1'b0;
        step();
        rst_n = 1'b0;
        step();
        chk("R2", "mid reset W", 16'(w_out), 16'h00);
        chk("R2", "mid reset status", 16'(flags_out), 16'h00);
        chk("R2", "mid reset phase", 16'(phase_out), 16'h0);
        rst_n = 1'b1;
        step();
        chk("R2", "after reset idle", 16'(phase_out), 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule